// File: doc/BRIEF.md
# Port Input Debounce Filter

This block cleans up the eight raw inputs of one general-purpose port before the rest of the chip sees them. Each pin can be switched into filtered mode on its own. A filtered pin changes its output only after its raw input has differed from the current output, without interruption, for a programmed number of one-millisecond ticks. All filtered pins of the port share a single 8-bit tick count, so one value sets the settle time for the whole port.

Software programs the block through a simple write port. One address takes the shared count. A second address takes a masked write to the per-pin enables: the upper byte selects which pins to touch and the lower byte gives their new state, so one pin can be changed without a read-modify-write. A free-running prescaler, sized from the clock frequency in kHz, supplies the millisecond tick. Pins that are not enabled, and all pins while the count is zero, pass straight through with one register of delay.

Top module: `port_debounce`

## Requirements
- R1: After reset every filtered output is 0, every pin is disabled (bypass) and the shared count is 0.
- R2: A disabled pin drives its output with the raw value of the previous clock cycle.
- R3: While the shared count is 0, enabled pins also pass through with one cycle of delay.
- R4: With count N > 0, an enabled pin's output takes the raw value only after the raw input has differed from the output on N tick pulses in a row; the output changes only on the clock edge that ends a tick cycle.
- R5: If the raw input of an enabled pin returns to the output value before N ticks, its stability count restarts and the output does not change.
- R6: A write to address 0x0C0 updates only the enables whose mask bit (data bits 15:8, bit 8 for pin 0) is 1, setting each to the matching value bit (bits 7:0); enables with mask bit 0 keep their state.
- R7: A write to address 0x0F0 loads data bits 7:0 into the single count shared by all enabled pins; writes to any other address change neither the count nor the enables.
- R8: The tick pulses for one cycle once every CLK_KHZ cycles, the first one CLK_KHZ cycles after reset.
- R9: The full count of 255 is honoured: the output waits between 254 and 255 tick periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | 2*NUM_PINS | Configuration write data |
| pin_raw | input | NUM_PINS | Raw pin levels, already synchronous to clk |
| pin_filt | output | NUM_PINS | Debounced pin levels |

## Verification
Assertions check on every cycle that the tick is a single-cycle pulse with a bounded prescaler, that a bypassed pin copies its raw value of the previous cycle, that a filtered pin never moves between ticks, that a raw value matching the output clears the stability count, and that enables without a mask bit and the count without a write hold their state. Only the bench's scenarios show the full settle time against the programmed count, the restart after a short glitch, the sharing of one count across pins, the 255-tick extreme and that stray addresses are ignored; a behavioural reference model is compared with the outputs on every clock.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
   localparam int unsigned DBNC_CNT_W = 8;
   typedef logic [DBNC_CNT_W-1:0] dbnc_cnt_t;
endpackage

// File: rtl/dbnc_tick_gen.sv
module dbnc_tick_gen #(
   parameter int unsigned CLK_KHZ = 200000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PRE_W = (CLK_KHZ > 1) ? $clog2(CLK_KHZ) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_KHZ - 1);

   logic [PRE_W-1:0] pre_q;

   assign tick = (pre_q == PRE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (tick) pre_q <= '0;
      else           pre_q <= pre_q + 1'b1;
   end

   AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= PRE_LAST); // R8

   generate
      if (CLK_KHZ > 1) begin : g_spacing
         AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick); // R8
      end
   endgenerate
endmodule

// File: rtl/dbnc_cfg_regs.sv
module dbnc_cfg_regs
   import dbnc_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] CNT_ADDR = 'h0F0,
   parameter logic [ADDR_W-1:0] ENA_ADDR = 'h0C0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [ADDR_W-1:0]     cfg_addr,
   input  logic [2*NUM_PINS-1:0] cfg_wdata,
   output logic [NUM_PINS-1:0]   pin_en,
   output dbnc_cnt_t             limit
);
   logic hit_cnt, hit_ena;

   assign hit_cnt = cfg_we && (cfg_addr == CNT_ADDR);
   assign hit_ena = cfg_we && (cfg_addr == ENA_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       limit <= '0;
      else if (hit_cnt) limit <= cfg_wdata[DBNC_CNT_W-1:0];
   end

   AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_cnt |=> $stable(limit)); // R7

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_en
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pin_en[i] <= 1'b0;
            else if (hit_ena && cfg_wdata[NUM_PINS+i])
               pin_en[i] <= cfg_wdata[i];
         end

         AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(hit_ena && cfg_wdata[NUM_PINS+i]) |=> $stable(pin_en[i])); // R6
      end
   endgenerate
endmodule

// File: rtl/dbnc_pin_filter.sv
module dbnc_pin_filter
   import dbnc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      enable,
   input  dbnc_cnt_t limit,
   input  logic      raw,
   output logic      filt
);
   dbnc_cnt_t             run_q;
   logic                  bypass;
   logic [DBNC_CNT_W:0]   next_run;

   assign bypass   = !enable || (limit == '0);
   assign next_run = {1'b0, run_q} + {{DBNC_CNT_W{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt  <= 1'b0;
         run_q <= '0;
      end else if (bypass) begin
         filt  <= raw;
         run_q <= '0;
      end else if (raw == filt) begin
         run_q <= '0;
      end else if (tick) begin
         if (next_run >= {1'b0, limit}) begin
            filt  <= raw;
            run_q <= '0;
         end else begin
            run_q <= next_run[DBNC_CNT_W-1:0];
         end
      end
   end

   AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (filt == $past(raw))); // R2, R3
   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && !tick) |=> $stable(filt)); // R4
   AST_GLITCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && (raw == filt)) |=> (run_q == '0)); // R5
endmodule

// File: rtl/port_debounce.sv
module port_debounce
   import dbnc_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned CLK_KHZ  = 200000,
   parameter int unsigned ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] CNT_ADDR = 'h0F0,
   parameter logic [ADDR_W-1:0] ENA_ADDR = 'h0C0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [ADDR_W-1:0]     cfg_addr,
   input  logic [2*NUM_PINS-1:0] cfg_wdata,
   input  logic [NUM_PINS-1:0]   pin_raw,
   output logic [NUM_PINS-1:0]   pin_filt
);
   localparam int unsigned DATA_W = 2 * NUM_PINS;

   generate
      if (NUM_PINS < 1)             begin : g_chk_pins  $error("NUM_PINS must be at least 1"); end
      if (DATA_W < DBNC_CNT_W)      begin : g_chk_data  $error("write data too narrow for the count"); end
      if (CLK_KHZ < 1)              begin : g_chk_clk   $error("CLK_KHZ must be at least 1"); end
      if (CNT_ADDR == ENA_ADDR)     begin : g_chk_addr  $error("register addresses must differ"); end
   endgenerate

   logic                tick;
   logic [NUM_PINS-1:0] pin_en;
   dbnc_cnt_t           limit;

   dbnc_tick_gen #(.CLK_KHZ(CLK_KHZ)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   dbnc_cfg_regs #(
      .NUM_PINS(NUM_PINS),
      .ADDR_W  (ADDR_W),
      .CNT_ADDR(CNT_ADDR),
      .ENA_ADDR(ENA_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .pin_en   (pin_en),
      .limit    (limit)
   );

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         dbnc_pin_filter u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .enable(pin_en[i]),
            .limit (limit),
            .raw   (pin_raw[i]),
            .filt  (pin_filt[i])
         );
      end
   endgenerate
endmodule

// File: tb/port_debounce_tb.sv
module port_debounce_tb;
   localparam int K = 4;
   localparam logic [11:0] A_CNT = 12'h0F0;
   localparam logic [11:0] A_ENA = 12'h0C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [7:0]  pin_raw = '0;
   logic [7:0]  pin_filt;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   string cur_req = "R1";

   // reference model state
   int m_pre = 0;
   int m_lim = 0;
   bit [7:0] m_en = '0;
   bit [7:0] m_filt = '0;
   int m_run [8];

   port_debounce #(.CLK_KHZ(K)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .pin_raw(pin_raw), .pin_filt(pin_filt)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_lim = 0; m_en = '0; m_filt = '0;
         foreach (m_run[p]) m_run[p] = 0;
      end else begin
         bit t;
         t = (m_pre == K - 1);
         m_pre = t ? 0 : m_pre + 1;
         for (int p = 0; p < 8; p++) begin
            if (!m_en[p] || m_lim == 0) begin
               m_filt[p] = pin_raw[p]; m_run[p] = 0;
            end else if (pin_raw[p] == m_filt[p]) begin
               m_run[p] = 0;
            end else if (t) begin
               m_run[p] = m_run[p] + 1;
               if (m_run[p] >= m_lim) begin
                  m_filt[p] = pin_raw[p]; m_run[p] = 0;
               end
            end
         end
         if (cfg_we && cfg_addr == A_CNT) m_lim = int'(cfg_wdata[7:0]);
         if (cfg_we && cfg_addr == A_ENA)
            for (int p = 0; p < 8; p++)
               if (cfg_wdata[8+p]) m_en[p] = cfg_wdata[p];
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         checks++;
         if (pin_filt !== m_filt) begin
            failures++;
            $display("FAIL %s model compare cycle %0d actual=%h expected=%h",
                     cur_req, cyc, pin_filt, m_filt);
         end
      end
      if (cyc == 150000) begin
         failures++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [7:0] exp);
      checks++;
      if (pin_filt !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, pin_filt, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg_write(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      chk("R1 reset output", 8'h00);

      // R2: disabled pins follow raw one cycle later
      cur_req = "R2";
      pin_raw = 8'hA5; wait_cyc(1); chk("R2 pass A5", 8'hA5);
      pin_raw = 8'h5A; wait_cyc(1); chk("R2 pass 5A", 8'h5A);
      pin_raw = 8'hFF; wait_cyc(1); chk("R2 pass FF", 8'hFF);
      pin_raw = 8'h00; wait_cyc(2); chk("R2 pass 00", 8'h00);

      // R4/R7/R8: count 3, enable pins 0..3
      cur_req = "R8";
      cfg_write(A_CNT, 16'h0003);
      cfg_write(A_ENA, 16'h0F0F);
      pin_raw = 8'h0F;
      wait_cyc(3);  chk("R4 held before count", 8'h00);
      wait_cyc(20); chk("R4 settled after count", 8'h0F);

      // R5: short glitch restarts stability count
      cur_req = "R5";
      pin_raw = 8'h0E; wait_cyc(6);
      pin_raw = 8'h0F; wait_cyc(1); chk("R5 glitch ignored", 8'h0F);
      wait_cyc(20); chk("R5 still stable", 8'h0F);

      // R6: masked write disables pin 0 only
      cur_req = "R6";
      cfg_write(A_ENA, 16'h0100);
      pin_raw = 8'h0C;
      wait_cyc(2);  chk("R6 pin0 bypass pin1 filtered", 8'h0E);
      wait_cyc(20); chk("R6 pin1 settled", 8'h0C);

      // R7: write to another address has no effect
      cur_req = "R7";
      cfg_write(12'h0F4, 16'hFFFF);
      pin_raw = 8'h88;
      wait_cyc(2);  chk("R7 stray write: pin7 bypass pin2 filtered", 8'h8C);
      wait_cyc(20); chk("R7 stray write: count unchanged", 8'h88);

      // R3: count 0 bypasses enabled pins
      cur_req = "R3";
      cfg_write(A_CNT, 16'h0000);
      pin_raw = 8'h03;
      wait_cyc(1); chk("R3 zero count bypass", 8'h03);

      // R9 with shared count (R7): 255 ticks
      cur_req = "R9";
      cfg_write(A_CNT, 16'h00FF);
      pin_raw = 8'h0F;
      wait_cyc(1000); chk("R9 held below 254 ticks", 8'h03);
      wait_cyc(30);   chk("R9 settled at 255 ticks, shared R7", 8'h0F);

      // R1: reset again restores bypass state
      cur_req = "R1";
      @(negedge clk); rst_n = 1'b0;
      wait_cyc(1); chk("R1 output cleared in reset", 8'h00);
      rst_n = 1'b1;
      pin_raw = 8'h0F;
      wait_cyc(1); chk("R1 enables cleared by reset", 8'h0F);

      wait_cyc(2);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule